// File: doc/BRIEF.md
# Receive Frame Packer with Host Readout Sequencer

This block takes incoming Ethernet frames as a byte stream, marked with start and end flags and carrying the frame length on every beat. It rebuilds each frame into a word FIFO. The stored image begins with a constant marker word and a length/status word. The payload follows, zero-padded up to the minimum frame size. Next comes a freshly computed CRC-32, and zero fill brings the image to a 4-byte boundary. Before a frame is stored, the block checks that receive is enabled and that the whole image fits in the free space. If either check fails, every byte of the frame is discarded.

A host drains the FIFO through a small register port. A sequencer tracks which word of the current packet comes next and learns the packet length from the length word. It decrements the stored-packet count when the last word of the packet has been read. A status flag and an interrupt line go high each time a packet is stored. Writing zero to the count register discards all stored data.

While the pad, CRC and fill bytes are being appended, the block holds the input stream with a ready signal.

Top module: `rx_frame_packer`

## Requirements
- R1: After reset the count register (address 1) reads 0, the status register (address 2) reads 0, `rx_irq` is low and `in_ready` is high.
- R2: A stored image starts with the word `MAGIC`, followed by a length word. The length word carries the padded payload length plus 4 in bits 15:0 and has bit 16 set as the OK flag, with all other bits zero. The payload follows it, four bytes per word, with the earliest byte in bits 7:0.
- R3: A payload shorter than 60 bytes is extended with zero bytes to 60 bytes, and the CRC covers the payload together with this pad.
- R4: The CRC is the reflected 0x04C11DB7 CRC-32 with an all-ones start value and a final inversion. It is placed in the byte stream immediately after the padded payload, least significant byte first. Zero bytes then fill the image up to the next 4-byte multiple.
- R5: A frame whose start beat arrives while `rx_en` is low is discarded completely, and the packet count does not change.
- R6: A frame is stored only if the free FIFO space, in words, is at least ceil((8 + padded + 4) / 4). Otherwise the whole frame is discarded, and a later frame that fits is still stored.
- R7: Reading the data register (address 0) returns successive words of the oldest packet. After its last word the count drops by one, and the next read returns the marker word of the following packet.
- R8: A data read while the count is 0 returns 0 and removes nothing from the FIFO.
- R9: Writing 0 to the count register empties the FIFO and clears the count and the read position. Writing a non-zero value there changes nothing.
- R10: Storing a packet sets bit 0 of the status register, and `rx_irq` follows that bit. Writing 1 to bit 0 clears it, unless a packet is stored in the same cycle, in which case the set wins.
- R11: `in_ready` is low from the cycle after the end beat until the image is complete.
- R12: The count register gives the number of complete stored packets when several are queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable, sampled on the start beat |
| in_valid | input | 1 | Byte beat valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_byte | input | 8 | Frame byte |
| in_len | input | 16 | Frame length in bytes, valid on the start beat |
| in_ready | output | 1 | Beat accepted when high together with in_valid |
| reg_addr | input | 2 | Register select: 0 data, 1 count, 2 status |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the strobe |
| rx_irq | output | 1 | Packet-stored interrupt |

## Verification
The assertions rely on frames arriving consistent with their metadata. `in_len` must equal the number of beats between the start and end flags, and no beat may carry a start flag inside a frame. Under those conditions the space check guarantees that the FIFO never receives a word while full. The bench drives every frame from one task that derives `in_len` from the same byte count it sends. It presents a beat only while `in_ready` is high. It issues flushes only while the input is idle.

// File: rtl/rxpk_pkg.sv
// Shared types and helpers for the receive frame packer.
// Assumes byte-serial CRC evaluation is acceptable in a single cycle.
package rxpk_pkg;

    typedef enum logic [1:0] {AS_IDLE, AS_BODY, AS_DROP, AS_TAIL} asm_state_t;
    typedef enum logic [1:0] {TL_PAD, TL_CRC, TL_FILL} tail_phase_t;
    typedef enum logic [1:0] {RP_MAGIC, RP_INFO, RP_DATA} rd_pos_t;

    localparam int          MIN_PAYLOAD  = 60;
    localparam logic [31:0] CRC_POLY_REV = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED     = 32'hFFFF_FFFF;

    // One byte of reflected CRC-32, LSB first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REV) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxpk_word_fifo.sv
// Word FIFO holding packed frame images.
// Assumes DEPTH is a power of two; overflow and underflow are prevented by the
// callers (admission check on write, packet count on read).
module rxpk_word_fifo #(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int UW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [31:0]   wr_data,
    input  logic          rd_en,
    output logic [31:0]   head,
    output logic [UW-1:0] used
);
    logic [31:0]   mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;

    assign head = mem[rptr_q];

    // Storage array write port.
    always_ff @(posedge clk) begin
        if (wr_en && !flush) mem[wptr_q] <= wr_data;
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
            used   <= '0;
        end else begin
            if (wr_en) wptr_q <= wptr_q + AW'(1);
            if (rd_en) rptr_q <= rptr_q + AW'(1);
            used <= used + UW'(wr_en) - UW'(rd_en);
        end
    end
endmodule

// File: rtl/rxpk_assembler.sv
// Frame assembler: admits or refuses a frame on its start beat, writes the
// marker and length words, packs payload bytes into words, then appends pad,
// CRC and alignment fill while holding the input stream.
// Assumes in_len matches the number of beats of the frame.
module rxpk_assembler
    import rxpk_pkg::*;
#(
    parameter int          DEPTH = 512,
    parameter logic [31:0] MAGIC = 32'hC0DE_5AA5,
    localparam int         UW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eof,
    input  logic [7:0]    in_byte,
    input  logic [15:0]   in_len,
    output logic          in_ready,
    input  logic [UW-1:0] free_words,
    input  logic          flush,
    output logic          wr_en,
    output logic [31:0]   wr_data,
    output logic          pkt_done
);
    asm_state_t  state_q;
    tail_phase_t tail_q;
    logic [23:0] acc_q;
    logic [1:0]  lane_q, cidx_q;
    logic [31:0] crc_q, info_q;
    logic [15:0] nbytes_q;
    logic        info_pend_q;

    logic [15:0] padded_req;
    logic [17:0] img_bytes;
    logic        start, accept, take, word_done, magic_w;
    logic [7:0]  bval;
    logic [31:0] crc_fin;

    // Admission arithmetic from the announced length.
    always_comb begin
        padded_req = (in_len < 16'(MIN_PAYLOAD)) ? 16'(MIN_PAYLOAD) : in_len;
        img_bytes  = {2'b00, padded_req} + 18'd15;
        start      = (state_q == AS_IDLE) && in_valid && in_sof;
        accept     = rx_en && !flush && (18'(free_words) >= (img_bytes >> 2));
        magic_w    = start && accept;
    end

    assign crc_fin  = ~crc_q;
    assign in_ready = (state_q != AS_TAIL);

    // Select the byte entering the word packer this cycle.
    always_comb begin
        take = 1'b0;
        bval = 8'h00;
        case (state_q)
            AS_IDLE: begin take = magic_w;  bval = in_byte; end
            AS_BODY: begin take = in_valid; bval = in_byte; end
            AS_TAIL: begin
                take = 1'b1;
                if (tail_q == TL_CRC) bval = crc_fin[{cidx_q, 3'b000} +: 8];
            end
            default: ;
        endcase
    end

    assign word_done = take && (lane_q == 2'd3);
    assign pkt_done  = !flush && (state_q == AS_TAIL) && (lane_q == 2'd3) &&
                       ((tail_q == TL_FILL) || (tail_q == TL_CRC && cidx_q == 2'd3));

    // Single write port: marker, length word, or a completed data word.
    always_comb begin
        wr_en   = !flush && (magic_w || info_pend_q || word_done);
        wr_data = magic_w ? MAGIC : (info_pend_q ? info_q : {bval, acc_q});
    end

    // Frame state, byte packing, CRC and byte counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= AS_IDLE;
            tail_q      <= TL_PAD;
            acc_q       <= '0;
            lane_q      <= '0;
            cidx_q      <= '0;
            crc_q       <= CRC_SEED;
            info_q      <= '0;
            nbytes_q    <= '0;
            info_pend_q <= 1'b0;
        end else if (flush) begin
            lane_q      <= '0;
            info_pend_q <= 1'b0;
            case (state_q)
                AS_BODY, AS_DROP: state_q <= (in_valid && in_eof) ? AS_IDLE : AS_DROP;
                AS_TAIL:          state_q <= AS_IDLE;
                default:          state_q <= (start && !in_eof) ? AS_DROP : AS_IDLE;
            endcase
        end else begin
            info_pend_q <= 1'b0;
            if (take) begin
                acc_q  <= {bval, acc_q[23:8]};
                lane_q <= lane_q + 2'd1;
            end
            case (state_q)
                AS_IDLE: if (start) begin
                    if (accept) begin
                        info_q      <= {15'd0, 1'b1, padded_req + 16'd4};
                        info_pend_q <= 1'b1;
                        crc_q       <= crc_step(CRC_SEED, in_byte);
                        nbytes_q    <= 16'd1;
                        tail_q      <= TL_PAD;
                        cidx_q      <= '0;
                        state_q     <= in_eof ? AS_TAIL : AS_BODY;
                    end else begin
                        state_q <= in_eof ? AS_IDLE : AS_DROP;
                    end
                end
                AS_BODY: if (in_valid) begin
                    crc_q    <= crc_step(crc_q, in_byte);
                    nbytes_q <= nbytes_q + 16'd1;
                    if (in_eof) begin
                        state_q <= AS_TAIL;
                        tail_q  <= (nbytes_q + 16'd1 < 16'(MIN_PAYLOAD)) ? TL_PAD : TL_CRC;
                        cidx_q  <= '0;
                    end
                end
                AS_DROP: if (in_valid && in_eof) state_q <= AS_IDLE;
                default: begin
                    case (tail_q)
                        TL_PAD: begin
                            crc_q    <= crc_step(crc_q, 8'h00);
                            nbytes_q <= nbytes_q + 16'd1;
                            if (nbytes_q + 16'd1 >= 16'(MIN_PAYLOAD)) tail_q <= TL_CRC;
                        end
                        TL_CRC: begin
                            cidx_q <= cidx_q + 2'd1;
                            if (cidx_q == 2'd3) begin
                                if (lane_q == 2'd3) state_q <= AS_IDLE;
                                else                tail_q  <= TL_FILL;
                            end
                        end
                        default: if (lane_q == 2'd3) state_q <= AS_IDLE;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/rxpk_readout.sv
// Host-side readout sequencer: walks marker, length and data words of the
// oldest packet and keeps the count of complete stored packets.
// Assumes the length field of every stored length word is at least 4.
module rxpk_readout
    import rxpk_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          pop_req,
    input  logic [15:0]   head_len,
    input  logic          pkt_done,
    output logic          pop,
    output logic [CW-1:0] cnt
);
    rd_pos_t     pos_q;
    logic [14:0] rem_q;
    logic        last;
    logic [16:0] len_up;

    assign pop    = pop_req && (cnt != '0);
    assign last   = pop && (pos_q == RP_DATA) && (rem_q == 15'd1);
    assign len_up = {1'b0, head_len} + 17'd3;

    // Position tracking, remaining words and packet count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            pos_q <= RP_MAGIC;
            rem_q <= '0;
            cnt   <= '0;
        end else begin
            if (pop) begin
                case (pos_q)
                    RP_MAGIC: pos_q <= RP_INFO;
                    RP_INFO: begin
                        rem_q <= len_up[16:2];
                        pos_q <= RP_DATA;
                    end
                    default: begin
                        rem_q <= rem_q - 15'd1;
                        if (rem_q == 15'd1) pos_q <= RP_MAGIC;
                    end
                endcase
            end
            cnt <= cnt + CW'(pkt_done) - CW'(last);
        end
    end
endmodule

// File: rtl/rx_frame_packer.sv
// Top level: frame assembler, word FIFO and readout sequencer, plus the host
// register port (0 data, 1 count, 2 status) and the receive interrupt.
// Assumes FIFO_BYTES is a power of two and at least 2048.
module rx_frame_packer #(
    parameter int          FIFO_BYTES = 2048,
    parameter logic [31:0] MAGIC      = 32'hC0DE_5AA5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_en,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic [7:0]  in_byte,
    input  logic [15:0] in_len,
    output logic        in_ready,
    input  logic [1:0]  reg_addr,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        rx_irq
);
    localparam int DEPTH_WORDS = FIFO_BYTES / 4;
    localparam int UW          = $clog2(DEPTH_WORDS + 1);
    localparam int CW          = 16;
    localparam logic [1:0] ADR_DATA = 2'd0;
    localparam logic [1:0] ADR_CNT  = 2'd1;
    localparam logic [1:0] ADR_STAT = 2'd2;

    logic          flush, pop_req, pop, fifo_wr, pkt_done, rx_flag;
    logic [31:0]   fifo_wdata, head;
    logic [UW-1:0] fifo_used, free_words;
    logic [CW-1:0] pkt_cnt;

    assign flush      = reg_wr && (reg_addr == ADR_CNT) && (reg_wdata == 32'd0);
    assign pop_req    = reg_rd && (reg_addr == ADR_DATA);
    assign free_words = UW'(DEPTH_WORDS) - fifo_used;
    assign rx_irq     = rx_flag;

    rxpk_assembler #(.DEPTH(DEPTH_WORDS), .MAGIC(MAGIC)) u_asm (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_byte(in_byte), .in_len(in_len), .in_ready(in_ready),
        .free_words(free_words), .flush(flush),
        .wr_en(fifo_wr), .wr_data(fifo_wdata), .pkt_done(pkt_done)
    );

    rxpk_word_fifo #(.DEPTH(DEPTH_WORDS)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(fifo_wr), .wr_data(fifo_wdata),
        .rd_en(pop), .head(head), .used(fifo_used)
    );

    rxpk_readout #(.CW(CW)) u_rd (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pop_req(pop_req),
        .head_len(head[15:0]), .pkt_done(pkt_done),
        .pop(pop), .cnt(pkt_cnt)
    );

    // Receive status flag: set on store, write-one-to-clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_flag <= 1'b0;
        else        rx_flag <= pkt_done ||
                               (rx_flag && !(reg_wr && reg_addr == ADR_STAT && reg_wdata[0]));
    end

    // Registered read data for the host port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                ADR_DATA: reg_rdata <= (pkt_cnt != '0) ? head : 32'd0;
                ADR_CNT:  reg_rdata <= 32'(pkt_cnt);
                ADR_STAT: reg_rdata <= {31'd0, rx_flag};
                default:  reg_rdata <= 32'd0;
            endcase
        end
    end
endmodule

// File: rtl/rxpk_checker.sv
// Property checker for rx_frame_packer, attached by bind.
// Assumes frames on the input match their announced lengths.
module rxpk_checker #(
    parameter int  FIFO_BYTES = 2048,
    localparam int DEPTH      = FIFO_BYTES / 4,
    localparam int UW         = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_wr,
    input logic [UW-1:0] fifo_used,
    input logic          pkt_done,
    input logic          rx_irq,
    input logic          reg_rd,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [31:0]   reg_rdata,
    input logic [15:0]   pkt_cnt
);
    // R6: admission keeps the FIFO from being written while full.
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (int'(fifo_used) < DEPTH));

    // R8: a data read with no stored packet yields zero.
    a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd0 && pkt_cnt == 16'd0) |=> (reg_rdata == 32'd0));

    // R10: a stored packet raises the interrupt on the next cycle.
    a_r10_irq_on_store: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> rx_irq);

    // R9: writing zero to the count register empties everything.
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && reg_wdata == 32'd0) |=> (pkt_cnt == 16'd0 && fifo_used == '0));

    // R12: the packet count moves by at most one per cycle outside a flush.
    a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 2'd1) |=>
            (pkt_cnt == $past(pkt_cnt) || pkt_cnt == $past(pkt_cnt) + 16'd1 ||
             pkt_cnt == $past(pkt_cnt) - 16'd1));
endmodule

bind rx_frame_packer rxpk_checker #(.FIFO_BYTES(FIFO_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_wr(fifo_wr), .fifo_used(fifo_used),
    .pkt_done(pkt_done), .rx_irq(rx_irq), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pkt_cnt(pkt_cnt)
);

// File: tb/rx_frame_packer_test.sv
module rx_frame_packer_test;
    localparam logic [31:0] MAGIC = 32'hC0DE_5AA5;

    logic        clk = 1'b0;
    logic        rst_n, rx_en, in_valid, in_sof, in_eof;
    logic [7:0]  in_byte;
    logic [15:0] in_len;
    logic        in_ready;
    logic [1:0]  reg_addr;
    logic        reg_rd, reg_wr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        rx_irq;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0]  img   [0:2047];
    logic [31:0] exp_w [0:599];
    int          exp_n;

    always #2 clk = ~clk;

    rx_frame_packer uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid),
        .in_sof(in_sof), .in_eof(in_eof), .in_byte(in_byte), .in_len(in_len),
        .in_ready(in_ready), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    function automatic logic [7:0] pbyte(input int seed, input int i);
        return 8'(seed * 31 + i * 7 + (i >> 3));
    endfunction

    function automatic logic [31:0] crc_b(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r = c;
        for (int k = 0; k < 8; k++) begin
            if ((r[0] ^ b[k]) == 1'b1) r = (r >> 1) ^ 32'hEDB8_8320;
            else                       r = r >> 1;
        end
        return r;
    endfunction

    // Expected stored image per R2, R3, R4.
    task automatic build(input int len, input int seed);
        int padded = (len < 60) ? 60 : len;
        int nb = 0;
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < padded; i++) begin
            img[nb] = (i < len) ? pbyte(seed, i) : 8'h00;
            c = crc_b(c, img[nb]);
            nb++;
        end
        c = ~c;
        for (int k = 0; k < 4; k++) begin img[nb] = c[8*k +: 8]; nb++; end
        while (nb % 4 != 0) begin img[nb] = 8'h00; nb++; end
        exp_w[0] = MAGIC;
        exp_w[1] = {15'd0, 1'b1, 16'(padded + 4)};
        for (int w = 0; w < nb / 4; w++)
            exp_w[2 + w] = {img[4*w+3], img[4*w+2], img[4*w+1], img[4*w]};
        exp_n = 2 + nb / 4;
    endtask

    task automatic send_frame(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            in_byte  = pbyte(seed, i);
            in_len   = 16'(len);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic wait_idle();
        while (!in_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic drain_check(input string req);
        logic [31:0] v;
        for (int w = 0; w < exp_n; w++) begin
            reg_read(2'd0, v);
            chk(req, v, exp_w[w]);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_read(2'd1, v); chk("R1 count", v, 0);
        reg_read(2'd2, v); chk("R1 status", v, 0);
        chk("R1 irq", 32'(rx_irq), 0);
        chk("R1 ready", 32'(in_ready), 1);
    endtask

    task automatic t_short_frame();
        logic [31:0] v;
        send_frame(20, 1);
        chk("R11 ready low in tail", 32'(in_ready), 0);
        wait_idle();
        reg_read(2'd1, v); chk("R12 count one", v, 1);
        reg_read(2'd2, v); chk("R10 status set", v, 1);
        chk("R10 irq high", 32'(rx_irq), 1);
        build(20, 1);
        drain_check("R2 R3 R4 short image");
        reg_read(2'd1, v); chk("R7 count after drain", v, 0);
    endtask

    task automatic t_irq_clear();
        logic [31:0] v;
        reg_write(2'd2, 32'd1);
        reg_read(2'd2, v); chk("R10 status cleared", v, 0);
        chk("R10 irq low", 32'(rx_irq), 0);
    endtask

    task automatic t_unaligned();
        send_frame(61, 2);
        wait_idle();
        build(61, 2);
        chk("R4 word count 61", 32'(exp_n), 19);
        drain_check("R4 unaligned image");
    endtask

    task automatic t_multi();
        logic [31:0] v;
        send_frame(64, 3);
        send_frame(100, 4);
        wait_idle();
        reg_read(2'd1, v); chk("R12 two queued", v, 2);
        build(64, 3);
        drain_check("R7 first packet");
        reg_read(2'd1, v); chk("R7 count dec", v, 1);
        build(100, 4);
        drain_check("R7 second packet");
        reg_read(2'd1, v); chk("R7 count zero", v, 0);
    endtask

    task automatic t_empty_read();
        logic [31:0] v;
        reg_read(2'd0, v); chk("R8 empty read", v, 0);
        reg_read(2'd0, v); chk("R8 empty read again", v, 0);
        send_frame(45, 5);
        wait_idle();
        build(45, 5);
        drain_check("R8 nothing popped");
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        reg_write(2'd2, 32'd1);
        rx_en = 1'b0;
        send_frame(40, 6);
        wait_idle();
        rx_en = 1'b1;
        reg_read(2'd1, v); chk("R5 count unchanged", v, 0);
        reg_read(2'd2, v); chk("R5 no status", v, 0);
        send_frame(40, 7);
        wait_idle();
        build(40, 7);
        drain_check("R5 next frame intact");
    endtask

    task automatic t_space();
        logic [31:0] v;
        send_frame(1500, 8);
        wait_idle();
        reg_read(2'd1, v); chk("R6 first big stored", v, 1);
        send_frame(1500, 9);
        wait_idle();
        reg_read(2'd1, v); chk("R6 second big refused", v, 1);
        send_frame(60, 10);
        wait_idle();
        reg_read(2'd1, v); chk("R6 small fits", v, 2);
        build(1500, 8);
        drain_check("R6 big image");
        build(60, 10);
        drain_check("R6 small image");
    endtask

    task automatic t_flush();
        logic [31:0] v;
        send_frame(70, 11);
        send_frame(80, 12);
        wait_idle();
        reg_write(2'd1, 32'd5);
        reg_read(2'd1, v); chk("R9 nonzero ignored", v, 2);
        reg_read(2'd0, v); chk("R9 read before flush", v, MAGIC);
        reg_write(2'd1, 32'd0);
        reg_read(2'd1, v); chk("R9 flushed count", v, 0);
        reg_read(2'd0, v); chk("R9 flushed data", v, 0);
        send_frame(30, 13);
        wait_idle();
        build(30, 13);
        drain_check("R9 after flush");
    endtask

    initial begin
        rst_n = 1'b0; rx_en = 1'b1; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        in_byte = 8'h00; in_len = 16'd0; reg_addr = 2'd0; reg_rd = 1'b0;
        reg_wr = 1'b0; reg_wdata = 32'd0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_short_frame();
        t_irq_clear();
        t_unaligned();
        t_multi();
        t_empty_read();
        t_disabled();
        t_space();
        t_flush();
        report();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule